// File: doc/BRIEF.md
# Programmable Clock Divider with Duty Control

This block divides a fast input clock by a programmed ratio and shapes the high time of each output period. The output is a divided clock-enable style waveform, `clk_out`, together with `tick`, a pulse one input cycle long that marks the start of every output period. Software-visible fields supply the divide value, an optional high-time value, a flag that selects whether the high-time value is used, and a mode bit. The mode bit chooses between zero-based interpretation (a field value v means v+1 cycles) and one-based interpretation (v means exactly v cycles). It applies to both fields.

A divide value of zero stops the divider, so it also acts as a gate. New field values take effect only at the end of the period in progress. When the divider is stopped, they take effect on the next input cycle. The mapping from field values to an effective period and high time is done combinationally. The period counter then holds these effective values, so the field inputs can change at any time without corrupting the waveform in flight.

Top module: `duty_divider`

## Requirements
- R1: With a divide field of 0 in either mode, once the divider reaches a period boundary `clk_out` and `tick` both stay low, and they stay low for as long as the field remains 0.
- R2: In zero-based mode (`one_based` = 0) a nonzero divide field v gives an output period of v+1 input cycles.
- R3: In one-based mode (`one_based` = 1) a nonzero divide field v gives an output period of exactly v input cycles, so v = 1 gives an output that is high on every cycle.
- R4: In zero-based mode with `hi_en` = 1, the output is high for the first h+1 cycles of each period, where h is the high-time field.
- R5: In one-based mode with `hi_en` = 1, the output is high for the first h cycles of each period, so h = 0 keeps the output low for the whole period while `tick` still pulses.
- R6: With `hi_en` = 0, the output is high for the first floor(P/2) cycles of a period of P cycles, and for at least one cycle.
- R7: A high time that is equal to or greater than the period saturates, so the output is high for the entire period.
- R8: Field changes made in the middle of a period do not alter that period. They apply from the first cycle of the next period, and that includes a change to 0, which gates the output.
- R9: `tick` is high on the first input cycle of each output period and low on every other cycle.
- R10: While `rst` is high, `clk_out` and `tick` are low. The first period begins on the cycle after the first clock edge at which reset is low and the divide field is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | DIV_W | Divide field; 0 gates the output |
| hi_val | input | HI_W | High-time field |
| hi_en | input | 1 | 1 uses `hi_val` for the high time, 0 uses the default half-period duty |
| one_based | input | 1 | 0 selects zero-based field interpretation, 1 selects one-based |
| clk_out | output | 1 | Divided output waveform |
| tick | output | 1 | One-cycle pulse on the first cycle of each output period |

## Verification
On every cycle the assertions check several invariants. The held high time never exceeds the held period. The period counter stays inside the period. The held configuration changes only at a period start. A stopped divider drives both outputs low. A tick is never followed by another tick when the period exceeds one cycle. The exact waveforms can only be shown by the bench's scenarios: the period length and high-time count for each mode and field combination, the default duty, saturation, and the deferred effect of changing fields, or gating, in the middle of a period.

// File: rtl/duty_div_pkg.sv
package duty_div_pkg;

    typedef enum logic {
        BASE_ZERO = 1'b0,
        BASE_ONE  = 1'b1
    } base_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    // Effective period in input cycles; 0 means stopped.
    function automatic logic [31:0] eff_period(base_mode_e mode, logic [31:0] field);
        if (field == 32'd0)
            return 32'd0;
        else if (mode == BASE_ONE)
            return field;
        else
            return field + 32'd1;
    endfunction

    // High time requested by the high-time field.
    function automatic logic [31:0] eff_high(base_mode_e mode, logic [31:0] field);
        if (mode == BASE_ONE)
            return field;
        else
            return field + 32'd1;
    endfunction

    // Default duty: half the period rounded down, never less than one cycle.
    function automatic logic [31:0] default_high(logic [31:0] per);
        logic [31:0] half;
        half = per >> 1;
        if (half == 32'd0)
            return 32'd1;
        else
            return half;
    endfunction

endpackage

// File: rtl/div_ratio_map.sv
module div_ratio_map
    import duty_div_pkg::*;
#(
    parameter int DIV_W = 6,
    parameter int HI_W  = 6,
    parameter int CNT_W = DIV_W + 1
) (
    input  logic [DIV_W-1:0] div_val,
    input  logic [HI_W-1:0]  hi_val,
    input  logic             hi_en,
    input  logic             one_based,
    output logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] high
);

    base_mode_e  mode;
    logic [31:0] per32;
    logic [31:0] req_hi32;
    logic [31:0] sat_hi32;

    always_comb begin
        mode     = one_based ? BASE_ONE : BASE_ZERO;
        per32    = eff_period(mode, 32'(div_val));
        req_hi32 = hi_en ? eff_high(mode, 32'(hi_val)) : default_high(per32);
        // Clip a high time that reaches past the end of the period.
        sat_hi32 = (req_hi32 > per32) ? per32 : req_hi32;
        per      = CNT_W'(per32);
        high     = CNT_W'(sat_hi32);
    end

endmodule

// File: rtl/div_period_ctr.sv
module div_period_ctr
    import duty_div_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] new_per,
    input  logic [CNT_W-1:0] new_high,
    output logic             nxt_active,
    output logic             nxt_first,
    output logic             nxt_high_phase,
    output div_state_e       state,
    output logic [CNT_W-1:0] held_per
);

    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] per_q, per_d;
    logic [CNT_W-1:0] high_q, high_d;
    logic             boundary;

    always_comb begin
        boundary = (state_q == ST_IDLE) || (cnt_q == per_q - CNT_W'(1));
        state_d  = state_q;
        cnt_d    = cnt_q + CNT_W'(1);
        per_d    = per_q;
        high_d   = high_q;
        if (boundary) begin
            cnt_d  = '0;
            per_d  = new_per;
            high_d = new_high;
            state_d = (new_per == '0) ? ST_IDLE : ST_RUN;
        end
        nxt_active     = (state_d == ST_RUN);
        nxt_first      = nxt_active && (cnt_d == '0);
        nxt_high_phase = nxt_active && (cnt_d < high_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            per_q   <= '0;
            high_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            per_q   <= per_d;
            high_q  <= high_d;
        end
    end

    assign state    = state_q;
    assign held_per = per_q;

    // R7
    sat_high_chk: assert property (@(posedge clk) disable iff (rst)
        high_q <= per_q);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (cnt_q < per_q));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && cnt_q != '0) |-> ($stable(per_q) && $stable(high_q)));

endmodule

// File: rtl/div_wave_gen.sv
module div_wave_gen (
    input  logic clk,
    input  logic rst,
    input  logic nxt_active,
    input  logic nxt_first,
    input  logic nxt_high_phase,
    output logic clk_out,
    output logic tick
);

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_out <= 1'b0;
            tick    <= 1'b0;
        end else begin
            clk_out <= nxt_active && nxt_high_phase;
            tick    <= nxt_active && nxt_first;
        end
    end

endmodule

// File: rtl/duty_divider.sv
module duty_divider
    import duty_div_pkg::*;
#(
    parameter int DIV_W = 6,
    parameter int HI_W  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    input  logic [HI_W-1:0]  hi_val,
    input  logic             hi_en,
    input  logic             one_based,
    output logic             clk_out,
    output logic             tick
);

    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] map_per;
    logic [CNT_W-1:0] map_high;
    logic             nxt_active;
    logic             nxt_first;
    logic             nxt_high_phase;
    div_state_e       ctr_state;
    logic [CNT_W-1:0] held_per;

    div_ratio_map #(
        .DIV_W (DIV_W),
        .HI_W  (HI_W),
        .CNT_W (CNT_W)
    ) u_map (
        .div_val   (div_val),
        .hi_val    (hi_val),
        .hi_en     (hi_en),
        .one_based (one_based),
        .per       (map_per),
        .high      (map_high)
    );

    div_period_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk            (clk),
        .rst            (rst),
        .new_per        (map_per),
        .new_high       (map_high),
        .nxt_active     (nxt_active),
        .nxt_first      (nxt_first),
        .nxt_high_phase (nxt_high_phase),
        .state          (ctr_state),
        .held_per       (held_per)
    );

    div_wave_gen u_wave (
        .clk            (clk),
        .rst            (rst),
        .nxt_active     (nxt_active),
        .nxt_first      (nxt_first),
        .nxt_high_phase (nxt_high_phase),
        .clk_out        (clk_out),
        .tick           (tick)
    );

    // R1
    gate_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ctr_state == ST_IDLE) |-> (!clk_out && !tick));

    // R9
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && held_per > CNT_W'(1)) |=> !tick);

endmodule

// File: tb/test_duty_divider.sv
`timescale 1ns/1ps
module test_duty_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] div_val = '0;
    logic [5:0] hi_val = '0;
    logic       hi_en = 1'b0;
    logic       one_based = 1'b0;
    logic       clk_out;
    logic       tick;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    duty_divider #(.DIV_W(6), .HI_W(6)) i_duty_divider (
        .clk       (clk),
        .rst       (rst),
        .div_val   (div_val),
        .hi_val    (hi_val),
        .hi_en     (hi_en),
        .one_based (one_based),
        .clk_out   (clk_out),
        .tick      (tick)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic        ob;
        logic        hen;
        logic [5:0]  dv;
        logic [5:0]  hv;
        logic [7:0]  per;
        logic [7:0]  hi;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{"R2 ", 1'b0, 1'b0, 6'd1,  6'd0, 8'd2,  8'd1},   // R2 R6
        '{"R6 ", 1'b0, 1'b0, 6'd4,  6'd0, 8'd5,  8'd2},   // R6 odd period
        '{"R4 ", 1'b0, 1'b1, 6'd7,  6'd2, 8'd8,  8'd3},   // R4
        '{"R5 ", 1'b1, 1'b1, 6'd5,  6'd2, 8'd5,  8'd2},   // R3 R5
        '{"R3 ", 1'b1, 1'b0, 6'd1,  6'd0, 8'd1,  8'd1},   // R3 divide by one
        '{"R5 ", 1'b1, 1'b1, 6'd4,  6'd0, 8'd4,  8'd0},   // R5 zero high
        '{"R7 ", 1'b0, 1'b1, 6'd3,  6'd9, 8'd4,  8'd4},   // R7 saturated
        '{"R7 ", 1'b1, 1'b1, 6'd6,  6'd6, 8'd6,  8'd6},   // R7 equal
        '{"R2 ", 1'b0, 1'b0, 6'd63, 6'd0, 8'd64, 8'd32},  // R2 largest
        '{"R3 ", 1'b1, 1'b0, 6'd63, 6'd0, 8'd63, 8'd31},  // R3 largest
        '{"R9 ", 1'b1, 1'b0, 6'd2,  6'd0, 8'd2,  8'd1}    // R9 R3
    };

    task automatic check(input string req, input int cyc,
                         input logic exp_out, input logic exp_tick);
        n_vec++;
        if (clk_out !== exp_out || tick !== exp_tick) begin
            n_bad++;
            $display("FAIL %s cyc %0d: clk_out=%0b exp=%0b tick=%0b exp=%0b",
                     req, cyc, clk_out, exp_out, tick, exp_tick);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R10: reset holds outputs low even with a nonzero divide field
        div_val = 6'd5;
        repeat (3) @(negedge clk);
        check("R10", 0, 1'b0, 1'b0);

        // Table walk: two periods per vector
        for (int v = 0; v < NV; v++) begin
            do_reset();
            one_based = VECS[v].ob;
            hi_en     = VECS[v].hen;
            div_val   = VECS[v].dv;
            hi_val    = VECS[v].hv;
            rst       = 1'b0;
            for (int i = 0; i < 2 * int'(VECS[v].per); i++) begin
                @(negedge clk);
                check(string'(VECS[v].tag), i,
                      (i % int'(VECS[v].per)) < int'(VECS[v].hi),
                      (i % int'(VECS[v].per)) == 0);
            end
        end

        // R1: zero divide field in both modes stays quiet
        for (int m = 0; m < 2; m++) begin
            do_reset();
            one_based = m[0];
            hi_en = 1'b1;
            hi_val = 6'd3;
            div_val = 6'd0;
            rst = 1'b0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                check("R1", i, 1'b0, 1'b0);
            end
        end

        // R8: change mid-period only applies at the next period
        do_reset();
        one_based = 1'b0; hi_en = 1'b0; div_val = 6'd7;
        rst = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (i < 8)
                check("R8", i, i < 4, i == 0);
            else
                check("R8", i, ((i - 8) % 2) == 0, ((i - 8) % 2) == 0);
            if (i == 2) begin
                div_val = 6'd1;
                one_based = 1'b0;
            end
        end

        // R8 R1: gating requested mid-period waits for the boundary
        do_reset();
        one_based = 1'b0; hi_en = 1'b1; hi_val = 6'd1; div_val = 6'd3;
        rst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i < 4)
                check("R8", i, i < 2, i == 0);
            else
                check("R1", i, 1'b0, 1'b0);
            if (i == 0) div_val = 6'd0;
        end

        // R10: a stopped divider restarts on the next edge
        div_val = 6'd1; hi_en = 1'b0;
        @(negedge clk);
        check("R10", 0, 1'b1, 1'b1);
        @(negedge clk);
        check("R10", 1, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule